// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Lock Indication

This block is the digital comparison stage of a two-channel frequency synthesizer. For each channel it watches two divided pulse trains: the divided reference and the divided feedback. It turns the rising-edge timing difference between them into two pump command strobes. The source strobe asks the charge pump to push current into the loop filter. The sink strobe asks it to pull current out. A per-channel output enable tells the external tri-state pump whether to drive at all.

Each channel has three controls. A polarity input swaps which detector branch drives the source strobe and which drives the sink strobe, so that a voltage-controlled oscillator with a falling tuning slope can be used. A float input releases the pump without stopping the detector. A sleep input stops the detector and the pump entirely.

A single lock output can be set to one of four things: a constant low, one channel's lock waveform, or a joint waveform for both channels. While the loops are settled, a lock waveform rests high and shows only brief low dips. Inputs are sampled on the system clock. One clock cycle is the unit of phase resolution.

Top module: `dual_pfd_lock`

## Requirements
- R1: While reset is held, and after release with no input edges, every src_o and snk_o bit is 0 and every oe_o bit is 1 (with float and sleep low). lock_o is 0 with lock_sel_i=0 and 1 with lock_sel_i=3.
- R2: A fc_i rising edge sampled at clock edge t raises the detector's UP branch from edge t. A fp_i rising edge raises the DOWN branch the same way. If fp_i rises d cycles after fc_i (d>=0), UP stays high d+1 cycles and DOWN stays high 1 cycle. The mirror case (fc_i rising -d cycles after fp_i) gives DOWN -d+1 cycles and UP 1 cycle.
- R3: Once UP and DOWN are both high, both are cleared on the next clock edge. Edges that coincide therefore give exactly one cycle of overlap.
- R4: A rising edge that arrives in the cycle in which both branches are being cleared is dropped and leaves no pulse behind.
- R5: With pol_i=1, src_o carries UP and snk_o carries DOWN. With pol_i=0, src_o carries DOWN and snk_o carries UP.
- R6: With hiz_i=1, that channel's oe_o is 0 while its src_o and snk_o keep following the detector.
- R7: With pd_i=1, that channel's src_o, snk_o and oe_o are 0, and its lock waveform stays high. After pd_i returns to 0, the channel measures the next edge pair normally.
- R8: A channel's lock waveform is low in exactly the cycles in which its UP or its DOWN branch is high.
- R9: lock_sel_i encoding: 0 selects a constant low, 1 selects channel 0's waveform, 2 selects channel 1's waveform, and 3 selects the joint waveform.
- R10: The joint waveform is high only when every channel's lock waveform is high. Its low cycles are the union of the channels' low cycles.
- R11: The channels are independent. Activity on one channel changes neither the strobes nor the lock waveform of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fc_i | input | NCH | Divided reference pulse, one bit per channel |
| fp_i | input | NCH | Divided feedback pulse, one bit per channel |
| pol_i | input | NCH | Detector polarity per channel (1 = rising-slope oscillator) |
| hiz_i | input | NCH | Float the pump output of a channel |
| pd_i | input | NCH | Sleep a channel's detector and pump |
| lock_sel_i | input | SELW | Lock output selection (see R9) |
| src_o | output | NCH | Pump source command per channel |
| snk_o | output | NCH | Pump sink command per channel |
| oe_o | output | NCH | Pump drive enable per channel |
| lock_o | output | 1 | Selected lock waveform |

## Verification
Two functions can fall in the same clock cycle here: the branch-clearing step that follows an UP/DOWN overlap, and the capture of a fresh rising edge. The bench provokes this collision by sending a one-cycle fc_i pulse, then an fp_i pulse one cycle later, then a second fc_i pulse exactly in the clearing cycle. It judges the result by counting source, sink and lock-low cycles, and expects the second edge to leave no trace. The edge-offset sweep also makes the two branches rise in the same cycle (zero offset) under both polarities. It checks that the overlap lasts exactly one cycle in the strobes and in the lock dip.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // per-channel control bundle
  typedef struct packed {
    logic pol;   // 1: UP drives source
    logic hiz;   // float the pump
    logic pd;    // sleep the channel
  } ch_ctrl_t;

  // width of the lock selector for a given channel count
  function automatic int sel_width(input int nch);
    return $clog2(nch + 2);
  endfunction
endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pfd_channel.sv
module pfd_channel
  import pfd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fc_i,
  input  logic     fp_i,
  input  ch_ctrl_t ctrl_i,
  output logic     src_o,
  output logic     snk_o,
  output logic     oe_o,
  output logic     lk_o
);
  logic fc_q, fp_q;
  logic up_q, dn_q;
  logic up_d, dn_d;
  logic fc_rise, fp_rise;
  logic edge_en;

  // edge history tracks the inputs always, so waking from sleep adds no edge
  assign edge_en = 1'b1;
  assign fc_rise = fc_i & ~fc_q;
  assign fp_rise = fp_i & ~fp_q;

  // next state of the two detector branches
  always_comb begin
    up_d = up_q;
    dn_d = dn_q;
    if (ctrl_i.pd) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else if (up_q && dn_q) begin
      // clearing cycle: both branches drop, new edges are not captured
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      up_d = up_q | fc_rise;
      dn_d = dn_q | fp_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q <= 1'b0;
      fp_q <= 1'b0;
    end else if (edge_en) begin
      fc_q <= fc_i;
      fp_q <= fp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  // polarity steering and pump gating
  always_comb begin
    if (ctrl_i.pol) begin
      src_o = up_q;
      snk_o = dn_q;
    end else begin
      src_o = dn_q;
      snk_o = up_q;
    end
    if (ctrl_i.pd) begin
      src_o = 1'b0;
      snk_o = 1'b0;
    end
    oe_o = ~(ctrl_i.hiz | ctrl_i.pd);
    lk_o = ~(up_q | dn_q);
  end
endmodule

// File: rtl/pfd_lock_sel.sv
module pfd_lock_sel #(
  parameter int NCH  = 2,
  parameter int SELW = 2
) (
  input  logic [NCH-1:0]  lk_i,
  input  logic [SELW-1:0] sel_i,
  output logic            lock_o
);
  localparam logic [SELW-1:0] SEL_ALL = SELW'(NCH + 1);

  always_comb begin
    lock_o = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (sel_i == SELW'(i + 1)) lock_o = lk_i[i];
    end
    if (sel_i == SEL_ALL) lock_o = &lk_i;
  end
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
  import pfd_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int SELW = pfd_pkg::sel_width(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  fc_i,
  input  logic [NCH-1:0]  fp_i,
  input  logic [NCH-1:0]  pol_i,
  input  logic [NCH-1:0]  hiz_i,
  input  logic [NCH-1:0]  pd_i,
  input  logic [SELW-1:0] lock_sel_i,
  output logic [NCH-1:0]  src_o,
  output logic [NCH-1:0]  snk_o,
  output logic [NCH-1:0]  oe_o,
  output logic            lock_o
);
  logic           rst_s_n;
  logic [NCH-1:0] lk;

  pfd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ch_ctrl_t ctrl;
    assign ctrl.pol = pol_i[g];
    assign ctrl.hiz = hiz_i[g];
    assign ctrl.pd  = pd_i[g];

    pfd_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .fc_i   (fc_i[g]),
      .fp_i   (fp_i[g]),
      .ctrl_i (ctrl),
      .src_o  (src_o[g]),
      .snk_o  (snk_o[g]),
      .oe_o   (oe_o[g]),
      .lk_o   (lk[g])
    );
  end

  pfd_lock_sel #(.NCH(NCH), .SELW(SELW)) u_sel (
    .lk_i   (lk),
    .sel_i  (lock_sel_i),
    .lock_o (lock_o)
  );
endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk #(
  parameter int NCH  = 2,
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  hiz_i,
  input logic [NCH-1:0]  pd_i,
  input logic [SELW-1:0] lock_sel_i,
  input logic [NCH-1:0]  src_o,
  input logic [NCH-1:0]  snk_o,
  input logic [NCH-1:0]  oe_o,
  input logic            lock_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      pd_i[g] |-> (!src_o[g] && !snk_o[g] && !oe_o[g])); // R7
    AST_FLOAT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_i[g] |-> !oe_o[g]); // R6
    AST_OVERLAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (src_o[g] && snk_o[g]) |=> (!src_o[g] && !snk_o[g])); // R3
    AST_LOCK_DIPS: assert property (@(posedge clk) disable iff (!rst_n)
      ((lock_sel_i == SELW'(g + 1)) && (src_o[g] || snk_o[g])) |-> !lock_o); // R8
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_sel_i == '0) |-> !lock_o); // R9
  AST_JOINT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_sel_i == SELW'(NCH + 1)) && lock_o) |-> ((src_o | snk_o) == '0)); // R10
endmodule

bind dual_pfd_lock dual_pfd_lock_chk #(.NCH(NCH), .SELW(SELW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hiz_i      (hiz_i),
  .pd_i       (pd_i),
  .lock_sel_i (lock_sel_i),
  .src_o      (src_o),
  .snk_o      (snk_o),
  .oe_o       (oe_o),
  .lock_o     (lock_o)
);

// File: tb/test_dual_pfd_lock.sv
`timescale 1ns/1ps
module test_dual_pfd_lock;
  localparam int NCH = 2;
  localparam int SELW = 2;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] fc, fp, pol, hiz, pd;
  logic [SELW-1:0] sel;
  logic [NCH-1:0] src, snk, oe;
  logic lock;

  int n_chk = 0;
  int n_err = 0;
  int c_src [NCH];
  int c_snk [NCH];
  int c_oe  [NCH];
  int c_lklow;

  always #2 clk = ~clk;

  dual_pfd_lock #(.NCH(NCH)) i_dual_pfd_lock (
    .clk(clk), .rst_n(rst_n), .fc_i(fc), .fp_i(fp), .pol_i(pol),
    .hiz_i(hiz), .pd_i(pd), .lock_sel_i(sel),
    .src_o(src), .snk_o(snk), .oe_o(oe), .lock_o(lock)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pulse2(input int t);
    return 32'(3) << t;
  endfunction

  // drive masks cycle by cycle, counting output cycles at each falling edge
  task automatic run(input logic [31:0] fc0, input logic [31:0] fp0,
                     input logic [31:0] fc1, input logic [31:0] fp1);
    for (int i = 0; i < NCH; i++) begin
      c_src[i] = 0; c_snk[i] = 0; c_oe[i] = 0;
    end
    c_lklow = 0;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        c_src[i] += int'(src[i]);
        c_snk[i] += int'(snk[i]);
        c_oe[i]  += int'(oe[i]);
      end
      c_lklow += int'(!lock);
      fc[0] = (c < 32) ? fc0[c] : 1'b0;
      fp[0] = (c < 32) ? fp0[c] : 1'b0;
      fc[1] = (c < 32) ? fc1[c] : 1'b0;
      fp[1] = (c < 32) ? fp1[c] : 1'b0;
    end
  endtask

  function automatic int up_w(input int d);
    return (d >= 0) ? d + 1 : 1;
  endfunction
  function automatic int dn_w(input int d);
    return (d <= 0) ? 1 - d : 1;
  endfunction
  function automatic int mag(input int d);
    return (d < 0) ? -d : d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fc = '0; fp = '0; pol = '1; hiz = '0; pd = '0; sel = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 src in reset", int'(src), 0);
    chk("R1 snk in reset", int'(snk), 0);
    chk("R1 oe in reset", int'(oe), 3);
    chk("R1 lock sel0 in reset", int'(lock), 0);
    sel = 2'd3;
    @(negedge clk);
    chk("R1 lock sel3 in reset", int'(lock), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 src after release", int'(src), 0);

    // R2 R3 R5 R8: offset sweep on both channels, both polarities
    for (int p = 0; p < 2; p++) begin
      for (int d = -3; d <= 3; d++) begin
        int e;
        int ex_s0, ex_k0, ex_s1, ex_k1;
        e = -d;
        pol = p[0] ? 2'b11 : 2'b00;
        sel = p[0] ? 2'd2 : 2'd1;
        run(pulse2(6), pulse2(6 + d), pulse2(6), pulse2(6 + e));
        ex_s0 = p[0] ? up_w(d) : dn_w(d);
        ex_k0 = p[0] ? dn_w(d) : up_w(d);
        ex_s1 = p[0] ? up_w(e) : dn_w(e);
        ex_k1 = p[0] ? dn_w(e) : up_w(e);
        chk($sformatf("R2 R5 src0 pol=%0d d=%0d", p, d), c_src[0], ex_s0);
        chk($sformatf("R2 R5 snk0 pol=%0d d=%0d", p, d), c_snk[0], ex_k0);
        chk($sformatf("R3 R5 src1 pol=%0d d=%0d", p, e), c_src[1], ex_s1);
        chk($sformatf("R3 R5 snk1 pol=%0d d=%0d", p, e), c_snk[1], ex_k1);
        chk($sformatf("R8 lock low sel=%0d d=%0d", sel, d), c_lklow, mag(d) + 1);
      end
    end

    // R4: edge arriving in the clearing cycle is dropped
    pol = 2'b11; sel = 2'd1;
    run((32'(1) << 6) | (32'(1) << 8), 32'(1) << 7, '0, '0);
    chk("R4 src after dropped edge", c_src[0], 2);
    chk("R4 snk after dropped edge", c_snk[0], 1);
    chk("R4 lock low", c_lklow, 2);

    // R10: joint lock, disjoint and overlapping dips
    sel = 2'd3;
    run(pulse2(4), pulse2(6), pulse2(14), pulse2(13));
    chk("R10 joint disjoint low", c_lklow, 5);
    run(pulse2(6), pulse2(9), pulse2(6), pulse2(7));
    chk("R10 joint overlap low", c_lklow, 4);

    // R9: selector 0 is a constant low
    sel = 2'd0;
    run(pulse2(6), pulse2(8), '0, '0);
    chk("R9 sel0 low cycles", c_lklow, WIN);

    // R11: activity on channel 1 only
    sel = 2'd1;
    run('0, '0, pulse2(6), pulse2(9));
    chk("R11 ch0 lock untouched", c_lklow, 0);
    chk("R11 ch0 src untouched", c_src[0], 0);
    chk("R11 ch1 src active", c_src[1], 4);

    // R6: float keeps detector, drops enable
    hiz = 2'b01;
    run(pulse2(6), pulse2(8), '0, '0);
    chk("R6 oe0 floated", c_oe[0], 0);
    chk("R6 oe1 driven", c_oe[1], WIN);
    chk("R6 src0 still pulses", c_src[0], 3);
    hiz = 2'b00;

    // R7: sleep silences channel 0, then recovery
    pd = 2'b01;
    run(pulse2(6), pulse2(8), pulse2(6), pulse2(7));
    chk("R7 src0 asleep", c_src[0], 0);
    chk("R7 snk0 asleep", c_snk[0], 0);
    chk("R7 oe0 asleep", c_oe[0], 0);
    chk("R7 lock0 stays high", c_lklow, 0);
    chk("R7 R11 src1 awake", c_src[1], 2);
    pd = 2'b00;
    run(pulse2(6), pulse2(7), '0, '0);
    chk("R7 src0 after wake", c_src[0], 2);
    chk("R7 snk0 after wake", c_snk[0], 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule